// File: doc/BRIEF.md
# Synchronous FIFO with Lagging Empty Flag

This block is a single-clock first-in first-out buffer that behaves like a discrete synchronous FIFO device. Its write port takes a data word with an active-low write strobe. Its read port takes an active-low read strobe and returns data through a registered output. An active-low empty flag tells the reader whether a word can be taken. The flag is a register that updates on the rising clock edge.

Each instance has a lag control input. When the lag control is high, the empty-to-non-empty change of the flag comes one clock later than the stored occupancy would allow. Two instances placed side by side, with different lag settings, then model two parallel devices that briefly disagree about being empty. Readout logic built around this block can be exercised against that skew before it is trusted with real parts.

A read strobe given while the flag shows empty is ignored, and the output keeps the last word read. The reader may leave the read strobe asserted against an empty buffer.

Top module: `fifo_skew`

## Requirements
- R1: While the synchronous active-high reset is high at a rising edge, the buffer is emptied, `empty_n` becomes 0 and `rd_data` becomes 0 after that edge.
- R2: With `lag_en` low, a write (`wr_n` = 0) into an empty buffer makes `empty_n` 1 after the same rising edge that stores the word.
- R3: With `lag_en` high, a write into an empty buffer leaves `empty_n` at 0 after the storing edge, and `empty_n` becomes 1 after the next edge. A write into a buffer whose flag already shows non-empty keeps `empty_n` at 1 regardless of `lag_en`.
- R4: A read (`rd_n` = 0) sampled while `empty_n` is 1 puts the oldest stored word on `rd_data` after that rising edge. Words leave in the order they were written.
- R5: A read sampled while `empty_n` is 0 is ignored: `rd_data` keeps its previous value and no stored word is consumed. Holding `rd_n` low across empty cycles is legal, and a later word is still delivered correctly.
- R6: While the flag is held at 0 by the lag with a word stored, reads are ignored and the stored word is not lost.
- R7: A read and a write in the same cycle with one word stored return the stored word, keep `empty_n` at 1, and leave the new word as the next to be read.
- R8: A read that removes the last stored word, with no write in that cycle, makes `empty_n` 0 after the same edge.
- R9: A write sampled while DEPTH words are stored is dropped. Reading afterwards returns exactly the first DEPTH words, and then `empty_n` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Write strobe, active low |
| wr_data | input | DW | Word to store |
| rd_n | input | 1 | Read strobe, active low |
| lag_en | input | 1 | Delays the rise of the empty flag by one cycle |
| rd_data | output | DW | Registered output word |
| empty_n | output | 1 | Empty flag, 0 = empty, 1 = word available |

## Verification
The hardest state to reach is the lag window: one word is stored, but the flag still reads empty and a read strobe is pending. The stimulus sets `lag_en`, writes one word, and holds `rd_n` low in the very next cycle. The bench then checks that the flag rises, that the output has not moved, and that the following read returns the held word. The overflow boundary is reached by writing two words past capacity and then draining the buffer, so the drain sequence shows exactly which writes were dropped.

// File: rtl/fifo_skew_pkg.sv
package fifo_skew_pkg;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/fifo_skew_store.sv
module fifo_skew_store #(
   parameter int DW    = 16,
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_req,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_req,
   output logic [DW-1:0] rd_data,
   output logic [CW-1:0] occ,
   output logic [CW-1:0] occ_next,
   output logic          ovf
);

   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic          wr_ok;

   assign wr_ok = wr_req && (occ != FULL);

   always_comb begin
      occ_next = occ;
      if (wr_ok && !rd_req)      occ_next = occ + 1'b1;
      else if (!wr_ok && rd_req) occ_next = occ - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wptr    <= '0;
         rptr    <= '0;
         occ     <= '0;
         rd_data <= '0;
         ovf     <= 1'b0;
      end else begin
         occ <= occ_next;
         if (wr_ok) wptr <= wptr + 1'b1;
         if (rd_req) begin
            rd_data <= mem[rptr];
            rptr    <= rptr + 1'b1;
         end
         if (wr_req && !wr_ok) ovf <= 1'b1;
      end
   end

endmodule

// File: rtl/fifo_skew_flag.sv
module fifo_skew_flag #(
   parameter int DEPTH = 16,
   localparam int CW   = $clog2(DEPTH) + 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          lag_en,
   input  logic [CW-1:0] occ_next,
   output logic          empty_n,
   output logic          lag_held
);

   logic hold;

   // Hold the flag low for exactly one extra cycle on the empty to non-empty change.
   assign hold = !empty_n && (occ_next != '0) && lag_en && !lag_held;

   always_ff @(posedge clk) begin
      if (rst) begin
         empty_n  <= 1'b0;
         lag_held <= 1'b0;
      end else begin
         empty_n  <= (occ_next != '0) && !hold;
         lag_held <= hold;
      end
   end

endmodule

// File: rtl/fifo_skew.sv
module fifo_skew #(
   parameter int DW    = 16,
   parameter int DEPTH = 16
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_n,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_n,
   input  logic          lag_en,
   output logic [DW-1:0] rd_data,
   output logic          empty_n
);

   import fifo_skew_pkg::*;

   localparam int CW = $clog2(DEPTH) + 1;

   generate
      if (!is_pow2(DEPTH) || DEPTH < 2) begin : g_bad_depth
         $error("fifo_skew: DEPTH must be a power of two of at least 2");
      end
      if (DW < 1) begin : g_bad_width
         $error("fifo_skew: DW must be at least 1");
      end
   endgenerate

   logic          rd_acc;
   logic [CW-1:0] occ, occ_next;
   logic          ovf, lag_held;

   // A read counts only when the flag visible to the reader shows non-empty.
   assign rd_acc = !rd_n && empty_n;

   fifo_skew_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
      .clk      (clk),
      .rst      (rst),
      .wr_req   (!wr_n),
      .wr_data  (wr_data),
      .rd_req   (rd_acc),
      .rd_data  (rd_data),
      .occ      (occ),
      .occ_next (occ_next),
      .ovf      (ovf)
   );

   fifo_skew_flag #(.DEPTH(DEPTH)) u_flag (
      .clk      (clk),
      .rst      (rst),
      .lag_en   (lag_en),
      .occ_next (occ_next),
      .empty_n  (empty_n),
      .lag_held (lag_held)
   );

endmodule

// File: rtl/fifo_skew_chk.sv
module fifo_skew_chk #(
   parameter int DW    = 16,
   parameter int DEPTH = 16,
   localparam int CW   = $clog2(DEPTH) + 1
) (
   input logic          clk,
   input logic          rst,
   input logic          wr_n,
   input logic          rd_n,
   input logic          lag_en,
   input logic [DW-1:0] rd_data,
   input logic          empty_n,
   input logic [CW-1:0] occ,
   input logic          ovf,
   input logic          lag_held
);

   localparam logic [CW-1:0] FULL = CW'(DEPTH);

   assert_reset_state_R1: assert property (@(posedge clk)
      rst |=> (!empty_n && rd_data == '0));

   assert_fast_rise_R2: assert property (@(posedge clk) disable iff (rst)
      (!lag_en && occ == '0 && !wr_n) |=> empty_n);

   assert_lagged_rise_R3: assert property (@(posedge clk) disable iff (rst)
      (lag_en && occ == '0 && !wr_n) |=> (!empty_n && lag_held));

   assert_lag_release_R3: assert property (@(posedge clk) disable iff (rst)
      lag_held |=> empty_n);

   assert_flag_backed_R4: assert property (@(posedge clk) disable iff (rst)
      empty_n |-> (occ != '0));

   assert_ignored_read_R5: assert property (@(posedge clk) disable iff (rst)
      (!empty_n && !rd_n) |=> $stable(rd_data));

   assert_last_read_R8: assert property (@(posedge clk) disable iff (rst)
      (empty_n && !rd_n && wr_n && occ == CW'(1)) |=> !empty_n);

   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
      (occ == FULL && !wr_n) |=> ovf);

   assert_occ_bound_R9: assert property (@(posedge clk) disable iff (rst)
      occ <= FULL);

endmodule

bind fifo_skew fifo_skew_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .wr_n     (wr_n),
   .rd_n     (rd_n),
   .lag_en   (lag_en),
   .rd_data  (rd_data),
   .empty_n  (empty_n),
   .occ      (occ),
   .ovf      (ovf),
   .lag_held (lag_held)
);

// File: tb/sim_fifo_skew.sv
`timescale 1ns/1ps
module sim_fifo_skew;

   localparam int DW    = 16;
   localparam int DEPTH = 16;

   logic          clk = 1'b0;
   logic          rst;
   logic          wr_n;
   logic [DW-1:0] wr_data;
   logic          rd_n;
   logic          lag_en;
   logic [DW-1:0] rd_data;
   logic          empty_n;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   fifo_skew #(.DW(DW), .DEPTH(DEPTH)) u0 (
      .clk     (clk),
      .rst     (rst),
      .wr_n    (wr_n),
      .wr_data (wr_data),
      .rd_n    (rd_n),
      .lag_en  (lag_en),
      .rd_data (rd_data),
      .empty_n (empty_n)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic idle();
      wr_n = 1'b1; rd_n = 1'b1;
   endtask

   task automatic t_reset();
      rst = 1'b1; idle(); lag_en = 1'b0; wr_data = '0;
      cyc(); cyc();
      chk("R1 empty_n", 32'(empty_n), 0);
      chk("R1 rd_data", 32'(rd_data), 0);
      rst = 1'b0;
      cyc();
   endtask

   task automatic t_basic();
      wr_n = 1'b0; wr_data = 16'h00A1; cyc(); idle();
      chk("R2 flag after write", 32'(empty_n), 1);
      rd_n = 1'b0; cyc(); idle();
      chk("R4 read word", 32'(rd_data), 32'h00A1);
      chk("R8 flag after last read", 32'(empty_n), 0);
   endtask

   task automatic t_idle_read();
      rd_n = 1'b0;
      for (int i = 0; i < 3; i++) begin
         cyc();
         chk("R5 held output", 32'(rd_data), 32'h00A1);
         chk("R5 flag stays empty", 32'(empty_n), 0);
      end
      wr_n = 1'b0; wr_data = 16'h00B2; cyc(); wr_n = 1'b1;
      chk("R5 read at empty ignored", 32'(rd_data), 32'h00A1);
      chk("R2 flag with read held", 32'(empty_n), 1);
      cyc(); idle();
      chk("R5 later word delivered", 32'(rd_data), 32'h00B2);
      chk("R8 flag drops", 32'(empty_n), 0);
   endtask

   task automatic t_lag();
      lag_en = 1'b1;
      wr_n = 1'b0; wr_data = 16'h00C3; cyc(); idle();
      chk("R3 flag lags", 32'(empty_n), 0);
      rd_n = 1'b0; cyc(); idle();
      chk("R3 flag rises one cycle later", 32'(empty_n), 1);
      chk("R6 read during lag ignored", 32'(rd_data), 32'h00B2);
      wr_n = 1'b0; wr_data = 16'h00C4; cyc(); idle();
      chk("R3 no lag when non-empty", 32'(empty_n), 1);
      rd_n = 1'b0; cyc();
      chk("R6 held word kept", 32'(rd_data), 32'h00C3);
      cyc(); idle();
      chk("R4 order", 32'(rd_data), 32'h00C4);
      chk("R8 flag drops after lag test", 32'(empty_n), 0);
      lag_en = 1'b0;
   endtask

   task automatic t_simul();
      wr_n = 1'b0; wr_data = 16'h00D5; cyc();
      wr_data = 16'h00E6; rd_n = 1'b0; cyc(); idle();
      chk("R7 stored word returned", 32'(rd_data), 32'h00D5);
      chk("R7 flag stays set", 32'(empty_n), 1);
      rd_n = 1'b0; cyc(); idle();
      chk("R7 new word next", 32'(rd_data), 32'h00E6);
      chk("R8 flag drops after simul", 32'(empty_n), 0);
   endtask

   task automatic t_full();
      for (int i = 0; i < DEPTH + 2; i++) begin
         wr_n = 1'b0; wr_data = 16'(16'h0100 + i); cyc();
      end
      idle();
      rd_n = 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
         cyc();
         chk("R9 drain word", 32'(rd_data), 32'(16'h0100 + i));
      end
      chk("R9 empty after DEPTH reads", 32'(empty_n), 0);
      cyc(); idle();
      chk("R9 dropped writes absent", 32'(rd_data), 32'(16'h0100 + DEPTH - 1));
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_basic();
      t_idle_read();
      t_lag();
      t_simul();
      t_full();
      t_reset();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule